// File: doc/BRIEF.md
# Microprogram Sequencer with Writable Control Store

This block is the control half of a microprogrammed processor. It holds a control store of 128 words of 20 bits and a control address register that points at the microinstruction being executed. In every cycle the word at the current address is read. Its three micro-operation fields go straight out to an external datapath, and its sequencing fields choose the next address. Each of the sixteen machine instructions has a four-word routine in the lower half of the store. The instruction fetch routine and any shared subroutines sit in the upper half, and execution starts at word 64 after reset.

The next address depends on two things. A 2-bit test field picks one status input: constant true, the indirect bit, the accumulator sign or the accumulator zero. A 2-bit branch field picks how the address is formed: jump, call, return, or a jump to the routine of the current opcode. A single return register holds the return address for one level of subroutine call. The store is filled through a load port that writes only while reset is held, so a microprogram can be supplied before execution begins.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, `car` becomes 64. Once reset is released, the outputs show the fields of word 64.
- R2: The word layout from the MSB is: micro-op A in [19:17], micro-op B in [16:14], micro-op C in [13:11], test in [10:9], branch in [8:7], target address in [6:0]. At all times `uop_a`, `uop_b` and `uop_c` equal the A, B and C fields of the word stored at `car`.
- R3: Branch code 0 is a jump. With test code 0 (always true), `car` becomes the target at the next edge.
- R4: Test code 1 selects `ind_bit`, code 2 selects `ac_sign` and code 3 selects `ac_zero`. For a jump whose selected test is false, `car` becomes `car`+1. When it is true, `car` becomes the target.
- R5: Branch code 1 is a call. When the test is true, the return register captures `car`+1 and `car` becomes the target. When the test is false, `car` becomes `car`+1 and the return register keeps its value.
- R6: Branch code 2 is a return. `car` becomes the return register's value whatever the test outcome.
- R7: Branch code 3 maps the opcode. `car` becomes {0, opcode[3:0], 00}, whatever the test outcome.
- R8: Falling through from word 127 wraps `car` to 0.
- R9: `ld_en` writes `ld_word` into word `ld_addr` only while `rst` is high. Outside reset it has no effect, and the stored words survive a reset taken without loading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; also enables loading |
| ld_en | input | 1 | Control store write strobe (effective only in reset) |
| ld_addr | input | 7 | Control store write address |
| ld_word | input | 20 | Microinstruction to write |
| opcode | input | 4 | Machine instruction opcode used by the map branch |
| ind_bit | input | 1 | Indirect addressing bit of the instruction |
| ac_sign | input | 1 | Accumulator sign status |
| ac_zero | input | 1 | Accumulator zero status |
| car | output | 7 | Current control address |
| uop_a | output | 3 | Micro-operation field A |
| uop_b | output | 3 | Micro-operation field B |
| uop_c | output | 3 | Micro-operation field C |

## Verification
A wrong next address shows at `car` on the very next edge. It also shifts the micro-op fields in that same cycle, because they are read from the address `car` holds. A corrupted return register stays hidden until the next return, which then resumes execution at the wrong word. For that reason the bench compares `car` and the fields against a behavioural model in every cycle, using random status inputs over a random microprogram that contains many calls and returns. A stray write to the store outside reset shows up only when that word is next executed, so the bench keeps strobing the load port during normal running and checks word 64 again after a reset taken without loading.

// File: rtl/useq_ctrl.sv
module useq_ctrl #(
  parameter int AW  = 7,
  parameter int FW  = 3,
  parameter int OPW = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ld_en,
  input  logic [AW-1:0]         ld_addr,
  input  logic [3*FW+AW+3:0]    ld_word,
  input  logic [OPW-1:0]        opcode,
  input  logic                  ind_bit,
  input  logic                  ac_sign,
  input  logic                  ac_zero,
  output logic [AW-1:0]         car,
  output logic [FW-1:0]         uop_a,
  output logic [FW-1:0]         uop_b,
  output logic [FW-1:0]         uop_c
);
  localparam int DEPTH = 1 << AW;
  localparam int BR_LO = AW;
  localparam int TS_LO = AW + 2;
  localparam int C_LO  = AW + 4;
  localparam int B_LO  = C_LO + FW;
  localparam int A_LO  = B_LO + FW;
  localparam int WW    = A_LO + FW;
  localparam int PADW  = AW - OPW - 2;
  localparam logic [AW-1:0] START = AW'(1) << (AW - 1);

  localparam logic [1:0] BR_JMP = 2'd0;
  localparam logic [1:0] BR_CALL = 2'd1;
  localparam logic [1:0] BR_RET = 2'd2;
  localparam logic [1:0] BR_MAP = 2'd3;

  logic [WW-1:0] store [DEPTH];
  logic [WW-1:0] word;
  logic [AW-1:0] sbr, nxt, inc, tgt;
  logic [1:0]    tsel, br;
  logic          hit;

  assign word  = store[car];
  assign uop_a = word[A_LO +: FW];
  assign uop_b = word[B_LO +: FW];
  assign uop_c = word[C_LO +: FW];
  assign tsel  = word[TS_LO +: 2];
  assign br    = word[BR_LO +: 2];
  assign tgt   = word[AW-1:0];
  assign inc   = car + AW'(1);

  always_comb begin
    case (tsel)
      2'd0:    hit = 1'b1;
      2'd1:    hit = ind_bit;
      2'd2:    hit = ac_sign;
      default: hit = ac_zero;
    endcase
  end

  always_comb begin
    case (br)
      BR_JMP, BR_CALL: nxt = hit ? tgt : inc;
      BR_RET:          nxt = sbr;
      default:         nxt = {{PADW{1'b0}}, opcode, 2'b00};
    endcase
  end

  always_ff @(posedge clk)
    if (rst && ld_en) store[ld_addr] <= ld_word;

  always_ff @(posedge clk)
    if (rst) car <= START;
    else     car <= nxt;

  always_ff @(posedge clk)
    if (!rst && br == BR_CALL && hit) sbr <= inc;

endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk #(
  parameter int AW  = 7,
  parameter int OPW = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [AW-1:0]  car,
  input logic [AW-1:0]  sbr,
  input logic [1:0]     br,
  input logic           hit,
  input logic [OPW-1:0] opcode
);
  localparam logic [AW-1:0] START = AW'(1) << (AW - 1);

  a_r1_reset_start: assert property (@(posedge clk) rst |=> car == START);

  a_r4_fall_through: assert property (@(posedge clk) disable iff (rst)
    (br == 2'd0 && !hit) |=> car == AW'($past(car) + AW'(1)));

  a_r5_call_saves: assert property (@(posedge clk) disable iff (rst)
    (br == 2'd1 && hit) |=> sbr == AW'($past(car) + AW'(1)));

  a_r5_sbr_held: assert property (@(posedge clk) disable iff (rst)
    !(br == 2'd1 && hit) |=> $stable(sbr));

  a_r6_return: assert property (@(posedge clk) disable iff (rst)
    br == 2'd2 |=> car == $past(sbr));

  a_r7_map: assert property (@(posedge clk) disable iff (rst)
    br == 2'd3 |=> car == AW'({$past(opcode), 2'b00}));
endmodule

bind useq_ctrl useq_ctrl_chk #(.AW(AW), .OPW(OPW)) u_chk (
  .clk(clk), .rst(rst), .car(car), .sbr(sbr), .br(br), .hit(hit), .opcode(opcode)
);

// File: tb/tb_useq_ctrl.sv
`timescale 1ns/1ps
module tb_useq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [6:0]  ld_addr = '0;
  logic [19:0] ld_word = '0;
  logic [3:0]  opcode = '0;
  logic        ind_bit = 1'b0, ac_sign = 1'b0, ac_zero = 1'b0;
  logic [6:0]  car;
  logic [2:0]  uop_a, uop_b, uop_c;

  useq_ctrl dut (.clk, .rst, .ld_en, .ld_addr, .ld_word, .opcode, .ind_bit,
                 .ac_sign, .ac_zero, .car, .uop_a, .uop_b, .uop_c);

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;
  logic [19:0] mem_m [128];
  int car_m, sbr_m;
  string tag = "R1";

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic compare(string fld_req);
    logic [19:0] w;
    w = mem_m[car_m];
    check(tag, int'(car), car_m);
    check(fld_req, int'({uop_a, uop_b, uop_c}), int'(w[19:11]));
  endtask

  // behavioural next-address model
  task automatic step();
    logic [19:0] w;
    int t, b, a, fall;
    bit c;
    w = mem_m[car_m];
    t = int'(w[10:9]); b = int'(w[8:7]); a = int'(w[6:0]);
    fall = (car_m + 1) % 128;
    c = (t == 0) ? 1'b1 : (t == 1) ? ind_bit : (t == 2) ? ac_sign : ac_zero;
    if (b == 0) begin
      tag = (t == 0) ? "R3" : "R4";
      car_m = c ? a : fall;
      if (!c && car_m == 0) tag = "R8";
    end else if (b == 1) begin
      tag = "R5";
      if (c) begin sbr_m = fall; car_m = a; end
      else begin car_m = fall; if (car_m == 0) tag = "R8"; end
    end else if (b == 2) begin
      tag = "R6"; car_m = sbr_m;
    end else begin
      tag = "R7"; car_m = int'(opcode) * 4;
    end
  endtask

  task automatic do_reset(bit load);
    rst = 1'b1;
    ld_en = 1'b0;
    @(negedge clk);
    if (load)
      for (int i = 0; i < 128; i++) begin
        ld_en = 1'b1; ld_addr = 7'(i); ld_word = mem_m[i];
        @(negedge clk);
      end
    ld_en = 1'b0;
    @(negedge clk);
    car_m = 64;
    tag = "R1";
    compare(load ? "R1" : "R9");
    rst = 1'b0;
    step();
  endtask

  task automatic run(int n, bit rnd);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare("R2");
      if (rnd) begin
        opcode = 4'($urandom); ind_bit = 1'($urandom);
        ac_sign = 1'($urandom); ac_zero = 1'($urandom);
        ld_en = 1'($urandom); ld_addr = 7'($urandom); ld_word = 20'($urandom);
      end else begin
        ind_bit = 1'b0; ld_en = 1'b1; ld_addr = 7'd64; ld_word = 20'hFFFFF;
      end
      step();
    end
    ld_en = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem_m[i] = 20'($urandom);
    mem_m[64] = {9'o123, 2'd0, 2'd1, 7'd65};   // call, always true
    do_reset(1'b1);
    run(4000, 1'b1);                             // R3..R7 and R9 writes outside reset
    do_reset(1'b0);                              // R9: contents kept
    run(600, 1'b1);
    mem_m[64]  = {9'o765, 2'd0, 2'd0, 7'd127};   // jump to last word
    mem_m[127] = {9'o042, 2'd1, 2'd0, 7'd10};    // jump on ind_bit, held 0 -> wrap (R8)
    do_reset(1'b1);
    run(3, 1'b0);
    run(600, 1'b1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule